// File: doc/BRIEF.md
# Slope Compensation Ramp Generator

This block supplies the falling reference that a peak current comparator works against. At every reload strobe from the PWM time base (a zero or period event, i.e. the start of each half switching cycle), a 16-bit countdown register is preset to the commanded peak current. On each following clock it drops by a programmable step. The upper 12 bits of the register form the code for the comparator DAC, so the reference falls at the chosen slope.

The peak reference and the step are written by software into holding (shadow) registers. They take effect only at the next reload, so a write at any point in a half cycle cannot disturb the ramp in progress. The four least significant bits of the countdown do not reach the DAC. They act as a fractional accumulator, so a step below 16 lowers the DAC code once every several clocks and very shallow slopes are possible. The ramp stops at zero. Once the comparator reports a trip, the ramp holds its value until the next reload.

Top module: `slope_ramp_gen`

## Requirements
- R1: A reload strobe loads the countdown register with the held peak reference on the next clock edge.
- R2: On each clock edge with no reload, no trip input and no held trip, the countdown register falls by exactly the active step.
- R3: The DAC code equals bits 15 down to 4 of the countdown register. The ramp status output presents all 16 bits.
- R4: Bits 3 down to 0 carry the fraction. With a step of 3, the DAC code drops by one each time the accumulated decrements cross a multiple of 16.
- R5: When the active step exceeds the remaining count, the register becomes zero and stays there. It never wraps.
- R6: A write to either holding register between reloads does not change the ramp's current value or its slope.
- R7: A trip input sampled high at a clock edge without reload stops the ramp at that edge. The value is held through later edges, even after trip falls, until a reload.
- R8: When reload and trip are high at the same edge, the reload wins. The register is preset and the ramp decrements again from the next edge.
- R9: A holding register write at the same edge as a reload does not take part in that reload. The reload uses the previous contents, and the new value applies from the following reload.
- R10: After reset the countdown register, the DAC code, the active step and both holding registers are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Ramp clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pk_ref_we | input | 1 | Write strobe for the peak reference holding register |
| pk_ref_in | input | 16 | Commanded peak current reference (starting count) |
| slope_we | input | 1 | Write strobe for the step holding register |
| slope_in | input | 16 | Decrement applied per clock |
| reload | input | 1 | Half-cycle start strobe from the PWM time base |
| trip | input | 1 | Comparator trip for the current half cycle |
| dac_code | output | 12 | Code for the comparator DAC |
| ramp_value | output | 16 | Full countdown register status |

## Verification
Every cycle, the assertions check the loading at reload, the exact per-clock decrement, the zero clamp and the monotonic fall, the hold after a trip, the priority of reload over trip, and that the active step only changes at a reload. Some behaviour can only be shown by the bench scenarios, which compare whole code sequences against values worked out from start value and step: the fractional carry that makes the DAC code move every few clocks, the isolation of mid-cycle and same-edge holding writes, and the zero state after reset.

// File: rtl/srg_pkg.sv
package srg_pkg;
  localparam int unsigned RAMP_W_DEF = 16;
  localparam int unsigned DAC_W_DEF  = 12;

  typedef enum logic [1:0] {
    ACT_LOAD  = 2'd0,
    ACT_HOLD  = 2'd1,
    ACT_STEP  = 2'd2,
    ACT_CLAMP = 2'd3
  } ramp_act_e;
endpackage

// File: rtl/srg_rst_sync.sv
module srg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/srg_shadow_bank.sv
module srg_shadow_bank #(
  parameter int unsigned RAMP_W = srg_pkg::RAMP_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_we,
  input  logic [RAMP_W-1:0] ref_in,
  input  logic              step_we,
  input  logic [RAMP_W-1:0] step_in,
  input  logic              reload,
  output logic [RAMP_W-1:0] load_ref,
  output logic [RAMP_W-1:0] act_step
);
  logic [RAMP_W-1:0] ref_sh_q,  ref_sh_d;
  logic [RAMP_W-1:0] step_sh_q, step_sh_d;
  logic [RAMP_W-1:0] step_act_q, step_act_d;

  // next state: holding registers take writes; active step moves on reload only
  always_comb begin
    ref_sh_d   = ref_sh_q;
    step_sh_d  = step_sh_q;
    step_act_d = step_act_q;
    if (ref_we)  ref_sh_d   = ref_in;
    if (step_we) step_sh_d  = step_in;
    if (reload)  step_act_d = step_sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sh_q   <= '0;
      step_sh_q  <= '0;
      step_act_q <= '0;
    end else begin
      ref_sh_q   <= ref_sh_d;
      step_sh_q  <= step_sh_d;
      step_act_q <= step_act_d;
    end
  end

  assign load_ref = ref_sh_q;
  assign act_step = step_act_q;

  // R6: active slope untouched between reloads
  p_step_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> $stable(step_act_q));

  // R9: a reload takes the step held before that edge
  p_step_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (step_act_q == $past(step_sh_q)));
endmodule

// File: rtl/srg_countdown.sv
module srg_countdown
  import srg_pkg::*;
#(
  parameter int unsigned RAMP_W = srg_pkg::RAMP_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic              trip,
  input  logic [RAMP_W-1:0] load_val,
  input  logic [RAMP_W-1:0] step,
  output logic [RAMP_W-1:0] ramp
);
  logic [RAMP_W-1:0] ramp_q, ramp_d;
  logic              frozen_q, frozen_d;
  ramp_act_e         act;

  // action select: reload has priority, then trip hold, then decrement
  always_comb begin
    if (reload)                 act = ACT_LOAD;
    else if (trip || frozen_q)  act = ACT_HOLD;
    else if (ramp_q >= step)    act = ACT_STEP;
    else                        act = ACT_CLAMP;
  end

  always_comb begin
    case (act)
      ACT_LOAD:  ramp_d = load_val;
      ACT_HOLD:  ramp_d = ramp_q;
      ACT_STEP:  ramp_d = ramp_q - step;
      default:   ramp_d = '0;
    endcase
    frozen_d = reload ? 1'b0 : (frozen_q | trip);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp_q   <= '0;
      frozen_q <= 1'b0;
    end else begin
      ramp_q   <= ramp_d;
      frozen_q <= frozen_d;
    end
  end

  assign ramp = ramp_q;

  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (ramp_q == $past(load_val)));

  p_decrement_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !trip && !frozen_q && ramp_q >= step)
      |=> (ramp_q == $past(ramp_q) - $past(step)));

  p_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !trip && !frozen_q && ramp_q < step) |=> (ramp_q == '0));

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> (ramp_q <= $past(ramp_q)));

  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && (trip || frozen_q)) |=> $stable(ramp_q));

  p_reload_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && trip) |=> !frozen_q);
endmodule

// File: rtl/slope_ramp_gen.sv
module slope_ramp_gen #(
  parameter int unsigned RAMP_W = srg_pkg::RAMP_W_DEF,
  parameter int unsigned DAC_W  = srg_pkg::DAC_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pk_ref_we,
  input  logic [RAMP_W-1:0] pk_ref_in,
  input  logic              slope_we,
  input  logic [RAMP_W-1:0] slope_in,
  input  logic              reload,
  input  logic              trip,
  output logic [DAC_W-1:0]  dac_code,
  output logic [RAMP_W-1:0] ramp_value
);
  localparam int unsigned FRAC_W = RAMP_W - DAC_W;

  logic              rst_n_i;
  logic [RAMP_W-1:0] load_ref;
  logic [RAMP_W-1:0] act_step;
  logic [RAMP_W-1:0] ramp;

  srg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  srg_shadow_bank #(.RAMP_W(RAMP_W)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .ref_we   (pk_ref_we),
    .ref_in   (pk_ref_in),
    .step_we  (slope_we),
    .step_in  (slope_in),
    .reload   (reload),
    .load_ref (load_ref),
    .act_step (act_step)
  );

  srg_countdown #(.RAMP_W(RAMP_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .reload   (reload),
    .trip     (trip),
    .load_val (load_ref),
    .step     (act_step),
    .ramp     (ramp)
  );

  // R3: DAC takes the integer part; fraction bits stay internal
  generate
    if (FRAC_W == 0) begin : g_no_frac
      assign dac_code = ramp;
    end else begin : g_frac
      assign dac_code = ramp[RAMP_W-1 -: DAC_W];
    end
  endgenerate

  assign ramp_value = ramp;
endmodule

// File: tb/test_slope_ramp_gen.sv
module test_slope_ramp_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pk_ref_we, slope_we, reload, trip;
  logic [15:0] pk_ref_in, slope_in;
  logic [11:0] dac_code;
  logic [15:0] ramp_value;
  int          n_chk = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  slope_ramp_gen i_slope_ramp_gen (
    .clk(clk), .rst_n(rst_n),
    .pk_ref_we(pk_ref_we), .pk_ref_in(pk_ref_in),
    .slope_we(slope_we), .slope_in(slope_in),
    .reload(reload), .trip(trip),
    .dac_code(dac_code), .ramp_value(ramp_value)
  );

  function automatic logic [15:0] expect_at(int unsigned start, int unsigned stp, int unsigned k);
    if (start > k * stp) return 16'(start - k * stp);
    return 16'h0;
  endfunction

  task automatic chk(string tag, int unsigned act, int unsigned exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_ramp(string tag, logic [15:0] exp);
    chk({tag, " ramp"}, ramp_value, exp);
    chk({tag, " R3 dac"}, dac_code, exp >> 4);
  endtask

  task automatic write_shadow(logic [15:0] r, logic [15:0] s);
    @(negedge clk);
    pk_ref_we = 1'b1; pk_ref_in = r; slope_we = 1'b1; slope_in = s;
    @(negedge clk);
    pk_ref_we = 1'b0; slope_we = 1'b0;
  endtask

  task automatic pulse_reload();
    @(negedge clk);
    reload = 1'b1;
    @(negedge clk);
    reload = 1'b0;
  endtask

  task automatic run_ramp(string tag, logic [15:0] r, logic [15:0] s, int n);
    write_shadow(r, s);
    pulse_reload();
    chk_ramp({tag, " R1 load"}, r);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      chk_ramp(tag, expect_at(r, s, k));
    end
  endtask

  task automatic t_reset();
    chk_ramp("R10 reset", 16'h0);
    pulse_reload();
    chk_ramp("R10 zero shadows", 16'h0);
    @(negedge clk);
    chk_ramp("R10 zero step", 16'h0);
  endtask

  task automatic t_shadow_mid();
    write_shadow(16'hA000, 16'h0200);
    pulse_reload();
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk_ramp("R6 pre", expect_at(16'hA000, 16'h0200, k));
    end
    // mid-cycle write takes two edges inside write_shadow
    write_shadow(16'h5000, 16'h0010);
    chk_ramp("R6 after write", expect_at(16'hA000, 16'h0200, 5));
    @(negedge clk);
    chk_ramp("R6 old slope", expect_at(16'hA000, 16'h0200, 6));
    pulse_reload();
    chk_ramp("R6 new ref", 16'h5000);
    @(negedge clk);
    chk_ramp("R6 new slope", 16'h4FF0);
  endtask

  task automatic t_trip();
    write_shadow(16'h9000, 16'h0250);
    pulse_reload();
    for (int k = 1; k <= 4; k++) @(negedge clk);
    chk_ramp("R7 before trip", expect_at(16'h9000, 16'h0250, 4));
    trip = 1'b1;
    @(negedge clk);
    trip = 1'b0;
    chk_ramp("R7 trip edge", expect_at(16'h9000, 16'h0250, 4));
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk_ramp("R7 held", expect_at(16'h9000, 16'h0250, 4));
    end
    @(negedge clk);
    reload = 1'b1; trip = 1'b1;
    @(negedge clk);
    reload = 1'b0; trip = 1'b0;
    chk_ramp("R8 reload wins", 16'h9000);
    @(negedge clk);
    chk_ramp("R8 runs again", 16'h8DB0);
  endtask

  task automatic t_same_edge();
    write_shadow(16'h4000, 16'h0100);
    @(negedge clk);
    reload = 1'b1;
    pk_ref_we = 1'b1; pk_ref_in = 16'h7000;
    slope_we  = 1'b1; slope_in  = 16'h0400;
    @(negedge clk);
    reload = 1'b0; pk_ref_we = 1'b0; slope_we = 1'b0;
    chk_ramp("R9 old ref", 16'h4000);
    @(negedge clk);
    chk_ramp("R9 old slope", 16'h3F00);
    pulse_reload();
    chk_ramp("R9 new ref", 16'h7000);
    @(negedge clk);
    chk_ramp("R9 new slope", 16'h6C00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pk_ref_we = 1'b0; slope_we = 1'b0; reload = 1'b0; trip = 1'b0;
    pk_ref_in = '0; slope_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    run_ramp("R2 steep", 16'hFFF0, 16'h0100, 8);
    run_ramp("R4 fractional", 16'h8000, 16'h0003, 24);
    run_ramp("R5 clamp", 16'h0100, 16'h0030, 10);
    run_ramp("R5 step above start", 16'h0020, 16'h0100, 3);
    run_ramp("R2 zero step", 16'h1234, 16'h0000, 4);
    t_shadow_mid();
    t_trip();
    t_same_edge();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule